// File: doc/BRIEF.md
# Dynamic Memory Refresh Arbiter

This block keeps a bank of dynamic read/write memory chips alive. A free-running interval timer raises a refresh request toward the processor. The refresh does not start until the processor answers with a grant, which the processor gives only while it sits between two instructions. Once the grant is taken, the block holds off the processor's next instruction and steps a row counter through every refresh row. For each row it runs one complete read cycle with every memory chip enabled at the same time, so that all of memory is restored in a single pass.

While the pass runs, the block blocks the data register from taking in the read data, because a refresh read carries no useful word. At the end of the pass it pulses a completion flag, releases the instruction hold and drops the request. With a 10 MHz clock the defaults give one row per microsecond, a 32-row pass of about 32 µs, and a request period a little under 2 ms.

Top module: `dram_refresh_ctl`

## Requirements
- R1: `rfsh_req` rises exactly once every `TIMER_PERIOD` clocks when every request is granted promptly, and it is never low for more than `TIMER_PERIOD` consecutive clocks.
- R2: Once raised, `rfsh_req` stays high until the cycle after `rfsh_done`. Timer expiries that occur while a request is already pending merge into it, so one grant yields exactly one pass.
- R3: A pass starts only on a clock edge where `rfsh_grant` and `rfsh_req` are both high. A grant while no request is pending has no effect: `instr_hold` stays low and no strobe appears.
- R4: `instr_hold` is high from the cycle after the accepted grant through the `rfsh_done` cycle inclusive, and low at all other times, including reset.
- R5: `row_addr` presents rows 0,1,…,`ROWS-1` in ascending order, one row per slot of `CLKS_PER_ROW` clocks, and starts from 0 on every pass. After the last row it wraps back to 0.
- R6: `rd_strobe` is high for the first `CLKS_PER_ROW-1` clocks of each row slot and low in the final clock of the slot. This gives exactly `ROWS` strobe pulses per pass.
- R7: `chip_en` is all ones during a pass and all zeros otherwise.
- R8: `capture_block` (1 = data register must not load) is high during every cycle of a pass.
- R9: `rfsh_done` is a single-cycle pulse in the last cycle of a pass. A pass lasts exactly `ROWS*CLKS_PER_ROW` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_grant | input | 1 | Processor permission to refresh, given between instructions |
| rfsh_req | output | 1 | Refresh wanted |
| instr_hold | output | 1 | Holds off the processor's next instruction |
| rfsh_done | output | 1 | One-cycle completion pulse |
| row_addr | output | $clog2(ROWS) | Refresh row on the memory address lines |
| rd_strobe | output | 1 | Read cycle strobe for the current row |
| chip_en | output | NUM_CHIPS | Per-chip enables, all set during refresh |
| capture_block | output | 1 | Suppresses the data register load |

## Verification
The bench builds the block with `TIMER_PERIOD=200`, `CLKS_PER_ROW=4`, `ROWS=32` and `NUM_CHIPS=8`. With these values a full 128-clock pass fits inside one timer period, so rise-to-rise spacing of exactly one period can be checked across several passes with different grant delays. The bench can also leave a request ungranted across more than two timer expiries, which shows that the request does not stack and that a single grant yields a single pass. The short row slot keeps all 32 rows and the wrap back to row 0 within a few hundred clocks.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic {
        RF_IDLE = 1'b0,
        RF_RUN  = 1'b1
    } rf_state_e;

    typedef struct packed {
        logic busy;
        logic strobe;
        logic done;
    } rf_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int unsigned PERIOD = 19000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned TW = rfsh_pkg::cnt_width(PERIOD);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int unsigned ROWS = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             step,
    output logic [rfsh_pkg::cnt_width(ROWS)-1:0] row,
    output logic                             at_last
);
    localparam int unsigned RW = rfsh_pkg::cnt_width(ROWS);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    assign at_last = (row == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)   row <= '0;
        else if (step)    row <= at_last ? '0 : row + 1'b1;
    end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq #(
    parameter int unsigned CLKS_PER_ROW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              grant,
    input  logic              row_last,
    output logic              req,
    output logic              row_clr,
    output logic              row_step,
    output rfsh_pkg::rf_ctl_t ctl
);
    import rfsh_pkg::*;

    localparam int unsigned SW = cnt_width(CLKS_PER_ROW);
    localparam logic [SW-1:0] SLOT_LAST = SW'(CLKS_PER_ROW - 1);

    rf_state_e st_q;
    logic [SW-1:0] slot_q;
    logic req_q;
    logic start, slot_end, finish;

    assign start    = (st_q == RF_IDLE) && req_q && grant;
    assign slot_end = (st_q == RF_RUN) && (slot_q == SLOT_LAST);
    assign finish   = slot_end && row_last;

    assign req      = req_q;
    assign row_clr  = start;
    assign row_step = slot_end;

    always_comb begin
        ctl.busy   = (st_q == RF_RUN);
        ctl.strobe = (st_q == RF_RUN) && (slot_q != SLOT_LAST);
        ctl.done   = finish;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RF_IDLE;
            slot_q <= '0;
            req_q  <= 1'b0;
        end else begin
            if (finish)    req_q <= tick;
            else if (tick) req_q <= 1'b1;

            case (st_q)
                RF_IDLE: begin
                    slot_q <= '0;
                    if (start) st_q <= RF_RUN;
                end
                RF_RUN: begin
                    if (slot_end) slot_q <= '0;
                    else          slot_q <= slot_q + 1'b1;
                    if (finish)   st_q <= RF_IDLE;
                end
                default: st_q <= RF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
    parameter int unsigned TIMER_PERIOD = 19000,
    parameter int unsigned CLKS_PER_ROW = 10,
    parameter int unsigned ROWS         = 32,
    parameter int unsigned NUM_CHIPS    = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  rfsh_grant,
    output logic                                  rfsh_req,
    output logic                                  instr_hold,
    output logic                                  rfsh_done,
    output logic [rfsh_pkg::cnt_width(ROWS)-1:0]  row_addr,
    output logic                                  rd_strobe,
    output logic [NUM_CHIPS-1:0]                  chip_en,
    output logic                                  capture_block
);
    import rfsh_pkg::*;

    logic tick, row_clr, row_step, row_last;
    rf_ctl_t ctl;

    rfsh_timer #(.PERIOD(TIMER_PERIOD)) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    rfsh_seq #(.CLKS_PER_ROW(CLKS_PER_ROW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .grant   (rfsh_grant),
        .row_last(row_last),
        .req     (rfsh_req),
        .row_clr (row_clr),
        .row_step(row_step),
        .ctl     (ctl)
    );

    rfsh_row_ctr #(.ROWS(ROWS)) u_row (
        .clk    (clk),
        .rst    (rst),
        .clr    (row_clr),
        .step   (row_step),
        .row    (row_addr),
        .at_last(row_last)
    );

    assign instr_hold    = ctl.busy;
    assign rfsh_done     = ctl.done;
    assign rd_strobe     = ctl.strobe;
    assign capture_block = ctl.busy;

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_ce
        assign chip_en[g] = ctl.busy;
    end
endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk #(
    parameter int unsigned PERIOD    = 19000,
    parameter int unsigned ROWS      = 32,
    parameter int unsigned NUM_CHIPS = 16
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 rfsh_grant,
    input logic                                 rfsh_req,
    input logic                                 instr_hold,
    input logic                                 rfsh_done,
    input logic [rfsh_pkg::cnt_width(ROWS)-1:0] row_addr,
    input logic                                 rd_strobe,
    input logic [NUM_CHIPS-1:0]                 chip_en,
    input logic                                 capture_block
);
    logic [31:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || rfsh_req) low_cnt <= '0;
        else                 low_cnt <= low_cnt + 1'b1;
    end

    assert_req_gap_R1: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= 32'(PERIOD));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        rfsh_req && !rfsh_done |=> rfsh_req);

    assert_start_on_grant_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(instr_hold) |-> $past(rfsh_grant && rfsh_req));

    assert_release_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        rfsh_done |=> !instr_hold);

    assert_row_stable_R5: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && $past(rd_strobe) |-> $stable(row_addr));

    assert_strobe_in_pass_R6: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> instr_hold);

    assert_all_chips_R7: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> (&chip_en));

    assert_no_capture_R8: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> capture_block);

    assert_done_in_pass_R9: assert property (@(posedge clk) disable iff (rst)
        rfsh_done |-> instr_hold && !rd_strobe);
endmodule

bind dram_refresh_ctl rfsh_chk #(
    .PERIOD   (TIMER_PERIOD),
    .ROWS     (ROWS),
    .NUM_CHIPS(NUM_CHIPS)
) u_chk (.*);

// File: tb/sim_dram_refresh_ctl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctl;
    localparam int P    = 200;
    localparam int CPR  = 4;
    localparam int ROWS = 32;
    localparam int NCH  = 8;
    localparam int AW   = $clog2(ROWS);

    logic clk = 1'b0, rst = 1'b1, grant = 1'b0;
    logic req, hold, done, strobe, capb;
    logic [AW-1:0]  row;
    logic [NCH-1:0] ce;

    always #2.5 clk = ~clk;

    dram_refresh_ctl #(.TIMER_PERIOD(P), .CLKS_PER_ROW(CPR), .ROWS(ROWS), .NUM_CHIPS(NCH)) u0 (
        .clk(clk), .rst(rst), .rfsh_grant(grant), .rfsh_req(req), .instr_hold(hold),
        .rfsh_done(done), .row_addr(row), .rd_strobe(strobe), .chip_en(ce), .capture_block(capb)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int exp_q[$];
    int strobe_cyc = 0;
    int last_rise = -1;
    bit space_on = 1'b1;
    bit prev_s = 1'b0, prev_r = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: rows against scoreboard, request spacing, pass-wide outputs
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (strobe) strobe_cyc++;
            if (strobe && !prev_s) begin
                if (exp_q.size() == 0) check(1'b0, "R3/R6 unexpected strobe", int'(row), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(row) == e, "R5 row order", int'(row), e);
                end
            end
            if (hold && !((&ce) && capb))
                check(1'b0, "R7/R8 enables in pass", int'(ce), (1 << NCH) - 1);
            if (!hold && (ce != '0 || capb))
                check(1'b0, "R7/R8 enables idle", int'(ce), 0);
            if (req && !prev_r) begin
                if (space_on && last_rise >= 0)
                    check(cyc - last_rise == P, "R1 request spacing", cyc - last_rise, P);
                last_rise = cyc;
            end
        end
        prev_s = strobe;
        prev_r = req;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", cyc, 100000);
            finish_run();
        end
    end

    // driver: grant after d cycles, push expected rows, measure the pass
    task automatic run_pass(input int d);
        int n = 0, dn = 0, at = -1;
        while (!req) @(negedge clk);
        for (int r = 0; r < ROWS; r++) exp_q.push_back(r);
        repeat (d) @(negedge clk);
        check(!hold, "R3 no start before grant", int'(hold), 0);
        strobe_cyc = 0;
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        check(hold, "R4 hold after grant", int'(hold), 1);
        while (hold) begin
            n++;
            if (done) begin dn++; at = n; end
            @(negedge clk);
        end
        check(n == ROWS * CPR, "R9 pass length", n, ROWS * CPR);
        check(dn == 1, "R9 single done", dn, 1);
        check(at == ROWS * CPR, "R9 done in last cycle", at, ROWS * CPR);
        check(!req, "R2 request cleared", int'(req), 0);
        check(row == '0, "R5 wrap to row 0", int'(row), 0);
        check(exp_q.size() == 0, "R6 all rows strobed", exp_q.size(), 0);
        check(strobe_cyc == ROWS * (CPR - 1), "R6 strobe duty", strobe_cyc, ROWS * (CPR - 1));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!req, "R1 reset request", int'(req), 0);
        check(!hold && !done, "R4 reset hold", int'(hold), 0);
        check(ce == '0 && !capb, "R7 reset enables", int'(ce), 0);
        check(row == '0 && !strobe, "R5 reset row", int'(row), 0);
        rst = 1'b0;

        run_pass(0);
        run_pass(3);
        run_pass(7);
        run_pass(1);

        // R3: grant with no request pending does nothing
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        check(!hold, "R3 stray grant ignored", int'(hold), 0);
        repeat (6) @(negedge clk);
        check(!hold && !strobe, "R3 no pass from stray grant", int'(hold), 0);

        // R2: request does not stack across expiries
        space_on = 1'b0;
        while (!req) @(negedge clk);
        begin
            int low = 0;
            for (int i = 0; i < 2 * P + 20; i++) begin
                if (!req) low++;
                @(negedge clk);
            end
            check(low == 0, "R2 request held while ungranted", low, 0);
        end
        run_pass(2);
        repeat (20) @(negedge clk);
        check(!hold && exp_q.size() == 0, "R2 one pass per grant", int'(hold), 0);

        finish_run();
    end
endmodule